// File: doc/BRIEF.md
# Indirect Branch Path History Queue

This block keeps, for one hardware thread, an ordered record of the indirect branches that are in flight. Each record holds the branch address, its target and the instruction sequence number. A predictor front end pushes a record when it predicts an indirect branch. It corrects the target of the newest record once the real target is known. It retires records as sequence numbers commit, and it cuts the record back to a given sequence number when the pipeline flushes.

The newest `PATH_LEN` targets, youngest first, are always on the `path_tgt` output, with a per-lane valid mask. An index hash in the predictor uses them. Retirement is lazy. A head counter first walks forward over committed records until `PATH_LEN` committed records are held behind it. After that, each further commit frees the oldest record, so the committed path stays available to the hash.

The storage is a circular buffer of `DEPTH` slots with an occupancy count. One operation is carried out per clock. Every operation takes effect at the rising edge, and its result shows on the outputs right after that edge.

Top module: `ind_path_hist`

## Requirements
- R1: After a synchronous reset, `occ` and `head_cnt` are 0, `path_vld` is all zero, and every `path_tgt` lane, `young_pc` and `young_seq` read 0.
- R2: A push appends (pc, target, seq) at the young end. `occ` rises by one, and `young_pc`/`young_seq` show the pushed values.
- R3: A push while `occ` equals `DEPTH` discards the oldest record. `occ` stays at `DEPTH`, and `head_cnt` drops by one unless it is already 0.
- R4: A set-target replaces only the target of the youngest record; its pc and seq are kept. On an empty queue it changes nothing.
- R5: A commit on an empty queue changes nothing.
- R6: A commit of sequence S advances `head_cnt` by one when `head_cnt` is below both `occ` and `PATH_LEN` and the record at position `head_cnt` (0 = oldest) has seq ≤ S.
- R7: When the same commit condition holds with `head_cnt` ≥ `PATH_LEN`, the oldest record is removed, `occ` falls by one and `head_cnt` is unchanged.
- R8: A commit changes nothing when `head_cnt` ≥ `occ`, or when the record at position `head_cnt` has seq > S. Sequence numbers compare as unsigned values.
- R9: A squash at S scans from the oldest record, finds the first one with seq > S, and removes it and every younger record. `head_cnt` is not altered. If no record qualifies, nothing is removed.
- R10: Lane i of `path_tgt` (bits i*TGT_W upward) carries the target of the i-th youngest record, with lane 0 the newest. `path_vld[i]` is 1 exactly when i < `occ`, and an invalid lane reads 0.
- R11: When several requests are raised in one cycle, only one is performed. Squash has the highest priority, then set-target, then push, then commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_vld | input | 1 | Append a record |
| push_pc | input | PC_W | Branch address of the new record |
| push_tgt | input | TGT_W | Predicted target of the new record |
| push_seq | input | SEQ_W | Sequence number of the new record |
| set_vld | input | 1 | Replace target of youngest record |
| set_tgt | input | TGT_W | Replacement target |
| cmt_vld | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Committed sequence number |
| sq_vld | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Last surviving sequence number |
| path_tgt | output | PATH_LEN*TGT_W | Youngest targets, lane 0 newest |
| path_vld | output | PATH_LEN | Lane valid mask |
| occ | output | $clog2(DEPTH+1) | Number of stored records |
| head_cnt | output | $clog2(DEPTH+1) | Retirement head counter |
| young_pc | output | PC_W | Branch address of youngest record, 0 if empty |
| young_seq | output | SEQ_W | Sequence number of youngest record, 0 if empty |

## Verification
Commit is driven with sequence numbers below, equal to and above the record at the head position. This separates the walk of the head counter from the pop of the oldest record, and also shows the stall once the counter reaches the occupancy. Squash is tried with a cut in the middle, with a cut beyond every record, with a cut below every record, and on records whose sequence numbers are not in order. The last case tells a first-greater scan apart from a count of all greater records. Pushing past full with a nonzero head counter shows the wrap of the ring and the counter adjustment. Paired requests in one cycle expose the priority order.

// File: rtl/phq_pkg.sv
package phq_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SQUASH = 3'd1,
    OP_SETTGT = 3'd2,
    OP_PUSH   = 3'd3,
    OP_COMMIT = 3'd4
  } phq_op_e;
endpackage

// File: rtl/phq_op_sel.sv
module phq_op_sel
  import phq_pkg::*;
(
  input  logic    sq_vld,
  input  logic    set_vld,
  input  logic    push_vld,
  input  logic    cmt_vld,
  output phq_op_e op
);
  // fixed priority: squash, set-target, push, commit
  always_comb begin
    if (sq_vld)        op = OP_SQUASH;
    else if (set_vld)  op = OP_SETTGT;
    else if (push_vld) op = OP_PUSH;
    else if (cmt_vld)  op = OP_COMMIT;
    else               op = OP_NONE;
  end
endmodule

// File: rtl/phq_store.sv
module phq_store #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 16,
  parameter int TGT_W = 16,
  parameter int SEQ_W = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   we_ent,
  input  logic [PTR_W-1:0]       wr_idx,
  input  logic [PC_W-1:0]        wr_pc,
  input  logic [TGT_W-1:0]       wr_tgt,
  input  logic [SEQ_W-1:0]       wr_seq,
  input  logic                   we_tgt,
  input  logic [PTR_W-1:0]       tgt_idx,
  input  logic [TGT_W-1:0]       tgt_val,
  output logic [DEPTH*PC_W-1:0]  pc_all,
  output logic [DEPTH*TGT_W-1:0] tgt_all,
  output logic [DEPTH*SEQ_W-1:0] seq_all
);
  logic [PC_W-1:0]  pc_mem  [DEPTH];
  logic [TGT_W-1:0] tgt_mem [DEPTH];
  logic [SEQ_W-1:0] seq_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_ent) begin
      pc_mem[wr_idx]  <= wr_pc;
      seq_mem[wr_idx] <= wr_seq;
    end
  end

  // target column has a second writer for the late correction
  always_ff @(posedge clk) begin
    if (we_ent)      tgt_mem[wr_idx]  <= wr_tgt;
    else if (we_tgt) tgt_mem[tgt_idx] <= tgt_val;
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_flat
    assign pc_all[s*PC_W +: PC_W]    = pc_mem[s];
    assign tgt_all[s*TGT_W +: TGT_W] = tgt_mem[s];
    assign seq_all[s*SEQ_W +: SEQ_W] = seq_mem[s];
  end
endmodule

// File: rtl/phq_scan.sv
module phq_scan #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic [DEPTH*SEQ_W-1:0] seq_all,
  input  logic [PTR_W-1:0]       rd_ptr,
  input  logic [CNT_W-1:0]       occ,
  input  logic [SEQ_W-1:0]       key,
  output logic [CNT_W-1:0]       keep
);
  // age-ordered scan: first record younger than key sets the new length
  always_comb begin
    logic             hit;
    logic [PTR_W-1:0] slot;
    keep = occ;
    hit  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      slot = PTR_W'(rd_ptr + PTR_W'(i));
      if (!hit && (CNT_W'(i) < occ) && (seq_all[slot*SEQ_W +: SEQ_W] > key)) begin
        keep = CNT_W'(i);
        hit  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ind_path_hist.sv
module ind_path_hist
  import phq_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int PATH_LEN = 3,
  parameter int PC_W     = 16,
  parameter int TGT_W    = 16,
  parameter int SEQ_W    = 8,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH+1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push_vld,
  input  logic [PC_W-1:0]           push_pc,
  input  logic [TGT_W-1:0]          push_tgt,
  input  logic [SEQ_W-1:0]          push_seq,
  input  logic                      set_vld,
  input  logic [TGT_W-1:0]          set_tgt,
  input  logic                      cmt_vld,
  input  logic [SEQ_W-1:0]          cmt_seq,
  input  logic                      sq_vld,
  input  logic [SEQ_W-1:0]          sq_seq,
  output logic [PATH_LEN*TGT_W-1:0] path_tgt,
  output logic [PATH_LEN-1:0]       path_vld,
  output logic [CNT_W-1:0]          occ,
  output logic [CNT_W-1:0]          head_cnt,
  output logic [PC_W-1:0]           young_pc,
  output logic [SEQ_W-1:0]          young_seq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] PATH_CNT = CNT_W'(PATH_LEN);

  phq_op_e          op;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] occ_q, hd_q, keep;
  logic [PTR_W-1:0] wr_idx, yng_idx, hd_idx;
  logic             full, cmt_go;
  logic [DEPTH*PC_W-1:0]  pc_all;
  logic [DEPTH*TGT_W-1:0] tgt_all;
  logic [DEPTH*SEQ_W-1:0] seq_all;

  phq_op_sel u_sel (
    .sq_vld  (sq_vld),
    .set_vld (set_vld),
    .push_vld(push_vld),
    .cmt_vld (cmt_vld),
    .op      (op)
  );

  assign full    = (occ_q == FULL_CNT);
  assign wr_idx  = PTR_W'(rd_ptr + occ_q[PTR_W-1:0]);
  assign yng_idx = PTR_W'(wr_idx - PTR_W'(1));
  assign hd_idx  = PTR_W'(rd_ptr + hd_q[PTR_W-1:0]);
  assign cmt_go  = (occ_q != '0) && (hd_q < occ_q) &&
                   (seq_all[hd_idx*SEQ_W +: SEQ_W] <= cmt_seq);

  phq_store #(.DEPTH(DEPTH), .PC_W(PC_W), .TGT_W(TGT_W), .SEQ_W(SEQ_W)) u_store (
    .clk    (clk),
    .we_ent (op == OP_PUSH),
    .wr_idx (wr_idx),
    .wr_pc  (push_pc),
    .wr_tgt (push_tgt),
    .wr_seq (push_seq),
    .we_tgt ((op == OP_SETTGT) && (occ_q != '0)),
    .tgt_idx(yng_idx),
    .tgt_val(set_tgt),
    .pc_all (pc_all),
    .tgt_all(tgt_all),
    .seq_all(seq_all)
  );

  phq_scan #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_scan (
    .seq_all(seq_all),
    .rd_ptr (rd_ptr),
    .occ    (occ_q),
    .key    (sq_seq),
    .keep   (keep)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      occ_q  <= '0;
      hd_q   <= '0;
    end else begin
      unique case (op)
        OP_SQUASH: occ_q <= keep;
        OP_PUSH: begin
          if (full) begin
            rd_ptr <= PTR_W'(rd_ptr + PTR_W'(1));
            if (hd_q != '0) hd_q <= hd_q - CNT_W'(1);
          end else begin
            occ_q <= occ_q + CNT_W'(1);
          end
        end
        OP_COMMIT: begin
          if (cmt_go) begin
            if (hd_q >= PATH_CNT) begin
              rd_ptr <= PTR_W'(rd_ptr + PTR_W'(1));
              occ_q  <= occ_q - CNT_W'(1);
            end else begin
              hd_q <= hd_q + CNT_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign occ       = occ_q;
  assign head_cnt  = hd_q;
  assign young_pc  = (occ_q != '0) ? pc_all[yng_idx*PC_W +: PC_W] : '0;
  assign young_seq = (occ_q != '0) ? seq_all[yng_idx*SEQ_W +: SEQ_W] : '0;

  for (genvar g = 0; g < PATH_LEN; g++) begin : g_lane
    logic [PTR_W-1:0] lidx;
    assign lidx = PTR_W'(wr_idx - PTR_W'(g + 1));
    assign path_vld[g] = (occ_q > CNT_W'(g));
    assign path_tgt[g*TGT_W +: TGT_W] = path_vld[g] ? tgt_all[lidx*TGT_W +: TGT_W] : '0;
  end

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst) occ_q <= FULL_CNT); // R3
  AST_HEAD_BOUND: assert property (@(posedge clk) disable iff (rst) hd_q <= PATH_CNT); // R6
  AST_PUSH_GROW: assert property (@(posedge clk) disable iff (rst) (push_vld && !sq_vld && !set_vld && !full) |=> (occ_q == $past(occ_q) + CNT_W'(1))); // R2
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst) (push_vld && !sq_vld && !set_vld && full) |=> (occ_q == FULL_CNT)); // R3
  AST_SQUASH_SHRINK: assert property (@(posedge clk) disable iff (rst) sq_vld |=> (occ_q <= $past(occ_q) && hd_q == $past(hd_q))); // R9
  AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (rst) (op == OP_COMMIT && occ_q == '0) |=> (occ_q == '0 && $stable(hd_q))); // R5
  AST_SET_KEEPS_LEN: assert property (@(posedge clk) disable iff (rst) (sq_vld == 1'b0 && set_vld) |=> ($stable(occ_q) && $stable(rd_ptr))); // R11
endmodule

// File: tb/tb_ind_path_hist.sv
module tb_ind_path_hist;
  localparam int DEPTH = 8, PL = 3, PC_W = 16, TGT_W = 16, SEQ_W = 8;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic clk = 1'b0, rst = 1'b1;
  logic push_vld = 0, set_vld = 0, cmt_vld = 0, sq_vld = 0;
  logic [PC_W-1:0]  push_pc = '0;
  logic [TGT_W-1:0] push_tgt = '0, set_tgt = '0;
  logic [SEQ_W-1:0] push_seq = '0, cmt_seq = '0, sq_seq = '0;
  logic [PL*TGT_W-1:0] path_tgt;
  logic [PL-1:0]       path_vld;
  logic [CNT_W-1:0]    occ, head_cnt;
  logic [PC_W-1:0]     young_pc;
  logic [SEQ_W-1:0]    young_seq;

  int errors = 0, checks = 0;

  // reference record
  logic [PC_W-1:0]  m_pc[$];
  logic [TGT_W-1:0] m_tg[$];
  logic [SEQ_W-1:0] m_sq[$];
  int m_hd = 0;

  always #5 clk = ~clk;

  ind_path_hist #(.DEPTH(DEPTH), .PATH_LEN(PL), .PC_W(PC_W), .TGT_W(TGT_W), .SEQ_W(SEQ_W)) dut (
    .clk(clk), .rst(rst),
    .push_vld(push_vld), .push_pc(push_pc), .push_tgt(push_tgt), .push_seq(push_seq),
    .set_vld(set_vld), .set_tgt(set_tgt),
    .cmt_vld(cmt_vld), .cmt_seq(cmt_seq),
    .sq_vld(sq_vld), .sq_seq(sq_seq),
    .path_tgt(path_tgt), .path_vld(path_vld),
    .occ(occ), .head_cnt(head_cnt), .young_pc(young_pc), .young_seq(young_seq)
  );

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic check_all(string rq);
    int n;
    n = m_sq.size();
    chk(rq, "occ", int'(occ), n);
    chk(rq, "head_cnt", int'(head_cnt), m_hd);
    chk(rq, "young_pc", int'(young_pc), n > 0 ? int'(m_pc[n-1]) : 0);
    chk(rq, "young_seq", int'(young_seq), n > 0 ? int'(m_sq[n-1]) : 0);
    for (int i = 0; i < PL; i++) begin
      chk(rq, $sformatf("path_vld[%0d]", i), int'(path_vld[i]), (i < n) ? 1 : 0);
      chk(rq, $sformatf("path_tgt[%0d]", i), int'(path_tgt[i*TGT_W +: TGT_W]),
          (i < n) ? int'(m_tg[n-1-i]) : 0);
    end
  endtask

  // one cycle with any mix of requests; model follows the priority order (R11)
  task automatic cyc(bit sq, bit st, bit pu, bit cm, logic [SEQ_W-1:0] s,
                     logic [PC_W-1:0] pc, logic [TGT_W-1:0] tg, string rq);
    @(negedge clk);
    sq_vld = sq; set_vld = st; push_vld = pu; cmt_vld = cm;
    sq_seq = s; cmt_seq = s; push_seq = s; push_pc = pc; push_tgt = tg; set_tgt = tg;
    @(posedge clk);
    #1;
    sq_vld = 0; set_vld = 0; push_vld = 0; cmt_vld = 0;
    if (sq) begin
      int cut;
      cut = m_sq.size();
      for (int i = m_sq.size() - 1; i >= 0; i--) if (m_sq[i] > s) cut = i;
      while (m_sq.size() > cut) begin
        void'(m_sq.pop_back()); void'(m_pc.pop_back()); void'(m_tg.pop_back());
      end
    end else if (st) begin
      if (m_sq.size() > 0) m_tg[m_tg.size()-1] = tg;
    end else if (pu) begin
      if (m_sq.size() == DEPTH) begin
        void'(m_sq.pop_front()); void'(m_pc.pop_front()); void'(m_tg.pop_front());
        if (m_hd > 0) m_hd--;
      end
      m_sq.push_back(s); m_pc.push_back(pc); m_tg.push_back(tg);
    end else if (cm) begin
      if (m_sq.size() > 0 && m_hd < m_sq.size() && m_sq[m_hd] <= s) begin
        if (m_hd >= PL) begin
          void'(m_sq.pop_front()); void'(m_pc.pop_front()); void'(m_tg.pop_front());
        end else m_hd++;
      end
    end
    check_all(rq);
  endtask

  task automatic push(logic [SEQ_W-1:0] s, logic [PC_W-1:0] pc, logic [TGT_W-1:0] tg, string rq);
    cyc(0, 0, 1, 0, s, pc, tg, rq);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    m_pc.delete(); m_tg.delete(); m_sq.delete(); m_hd = 0;
    check_all("R1");
  endtask

  task automatic t_push_path();
    do_reset();
    for (int i = 0; i < 5; i++) push(SEQ_W'(i + 1), PC_W'(16'h100 + i), TGT_W'(16'hA00 + i), "R2 R10");
  endtask

  task automatic t_set_target();
    do_reset();
    cyc(0, 1, 0, 0, 8'd0, 16'h0, 16'h1234, "R4");
    push(8'd7, 16'h300, 16'h0B00, "R2");
    push(8'd8, 16'h301, 16'h0B01, "R2");
    cyc(0, 1, 0, 0, 8'd0, 16'h0, 16'hBEEF, "R4");
  endtask

  task automatic t_commit();
    do_reset();
    cyc(0, 0, 0, 1, 8'd50, 16'h0, 16'h0, "R5");
    for (int i = 0; i < 4; i++) push(SEQ_W'(10 + i), PC_W'(16'h200 + i), TGT_W'(16'hC00 + i), "R2");
    cyc(0, 0, 0, 1, 8'd9,  16'h0, 16'h0, "R8");
    cyc(0, 0, 0, 1, 8'd10, 16'h0, 16'h0, "R6");
    cyc(0, 0, 0, 1, 8'd11, 16'h0, 16'h0, "R6");
    cyc(0, 0, 0, 1, 8'd12, 16'h0, 16'h0, "R6");
    cyc(0, 0, 0, 1, 8'd13, 16'h0, 16'h0, "R7");
    cyc(0, 0, 0, 1, 8'd13, 16'h0, 16'h0, "R8");
  endtask

  task automatic t_squash();
    do_reset();
    for (int i = 0; i < 5; i++) push(SEQ_W'(20 + i), PC_W'(16'h400 + i), TGT_W'(16'hD00 + i), "R2");
    cyc(1, 0, 0, 0, 8'd30, 16'h0, 16'h0, "R9");
    cyc(1, 0, 0, 0, 8'd22, 16'h0, 16'h0, "R9");
    cyc(1, 0, 0, 0, 8'd5,  16'h0, 16'h0, "R9");
    push(8'd5, 16'h500, 16'hE00, "R2");
    push(8'd9, 16'h501, 16'hE01, "R2");
    push(8'd3, 16'h502, 16'hE02, "R2");
    cyc(1, 0, 0, 0, 8'd6, 16'h0, 16'h0, "R9");
  endtask

  task automatic t_full();
    do_reset();
    for (int i = 0; i < DEPTH; i++) push(SEQ_W'(40 + i), PC_W'(16'h600 + i), TGT_W'(16'hF00 + i), "R2");
    cyc(0, 0, 0, 1, 8'd41, 16'h0, 16'h0, "R6");
    cyc(0, 0, 0, 1, 8'd41, 16'h0, 16'h0, "R6");
    push(8'd60, 16'h700, 16'h1700, "R3");
    push(8'd61, 16'h701, 16'h1701, "R3");
    push(8'd62, 16'h702, 16'h1702, "R3");
  endtask

  task automatic t_priority();
    do_reset();
    push(8'd1, 16'h800, 16'h1800, "R2");
    push(8'd2, 16'h801, 16'h1801, "R2");
    cyc(0, 0, 1, 1, 8'd3, 16'h802, 16'h1802, "R11");
    cyc(0, 1, 1, 0, 8'd4, 16'h803, 16'h2222, "R11");
    cyc(1, 1, 1, 1, 8'd1, 16'h804, 16'h3333, "R11");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_push_path();
    t_set_target();
    t_commit();
    t_squash();
    t_full();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule